// File: doc/BRIEF.md
# Dual-Channel Stepped Voltage-Code Ramp Sequencer

This block drives the voltage-select codes of two buck regulator channels for dynamic voltage scaling. Each channel holds an applied 5-bit code that feeds an analog reference outside the block, and a target code taken from a simple parallel write port (a code plus a one-cycle write strobe). When a new target is accepted, the applied code either jumps to it at once or walks toward it one code at a time. With walking enabled, every code on the way is held for a fixed dwell of 32 µs, so a change of n codes takes n dwells.

Each channel accepts only codes inside its own window. Codes outside the window are dropped. Channel 0 moves 50 mV per code over 1.00 V to 2.00 V. Channel 1 moves 100 mV per code over 1.8 V to 3.3 V. A shared enable selects walking or immediate application. Each channel reports a busy level and a one-cycle done pulse.

Top module: `dvs_ramp_seq`

## Requirements
- R1: After reset, `code0` is CH0_INIT (default 8), `code1` is CH1_INIT (default 25), and all busy and done outputs are 0.
- R2: A write is accepted only when its code lies in the channel's inclusive window: 4 to 24 for channel 0 (1.00 V to 2.00 V, 50 mV per code) and 10 to 25 for channel 1 (1.8 V to 3.3 V, 100 mV per code). The applied code never leaves this window.
- R3: A write whose code is outside the window changes neither the applied code nor the target. Busy and done stay 0 when the channel was idle.
- R4: With `microStepEn` low, an accepted code appears on the channel's code output right after the clock edge that samples the strobe.
- R5: With `microStepEn` high, the applied code moves by exactly one code per step toward the target. The first step comes DWELL clock cycles after the edge that sampled the write, and each further step comes DWELL cycles after the previous one.
- R6: A ramp of n codes completes n×DWELL cycles after the write edge. The code is still one short of the target one cycle before that point.
- R7: A write accepted mid-ramp makes the channel continue from its present code toward the new target, in either direction. The dwell restarts at that write.
- R8: `busyN` is 1 exactly while the channel's applied code differs from its target.
- R9: `doneN` is a one-cycle pulse in the first cycle in which the applied code equals the target after an accepted write. This includes a write equal to the present code.
- R10: Clearing `microStepEn` while a channel is ramping moves its applied code to the target at the next clock edge.
- R11: DWELL equals CLK_HZ × DWELL_US / 1,000,000 clock cycles. The default is 32 µs.
- R12: The two channels are independent. A write or ramp on one never changes the other channel's code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| microStepEn | input | 1 | 1: walk one code per dwell; 0: apply targets at once |
| wrStb0 | input | 1 | Write strobe, channel 0 |
| wrCode0 | input | 5 | Target code, channel 0 |
| wrStb1 | input | 1 | Write strobe, channel 1 |
| wrCode1 | input | 5 | Target code, channel 1 |
| code0 | output | 5 | Applied code, channel 0 |
| busy0 | output | 1 | Channel 0 applied code differs from target |
| done0 | output | 1 | Channel 0 reached target (one-cycle pulse) |
| code1 | output | 5 | Applied code, channel 1 |
| busy1 | output | 1 | Channel 1 applied code differs from target |
| done1 | output | 1 | Channel 1 reached target (one-cycle pulse) |

## Verification
Some properties hold on every cycle and are checked by assertions: the applied code stays inside its window, it never moves by more than one code except on a jump, the target holds unless a write is accepted, steps are never adjacent, done lasts one cycle and never overlaps busy, and a cleared enable leaves no channel busy. Other behaviour can only be shown by the bench scenarios. This covers the exact dwell count before each step, the total ramp length for several distances and both directions, the restart of the dwell on a mid-ramp retarget, rejection at both window edges, and the independence of the two channels.

// File: rtl/dvs_pkg.sv
package dvs_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture the written code as target
    logic snap;    // applied code jumps (to written code on load, else to target)
    logic stepUp;  // applied code + 1
    logic stepDn;  // applied code - 1
  } dpStrb_t;

  // status from datapath to control
  typedef struct packed {
    logic eq;        // applied code equals target
    logic tgtAbove;  // target above applied code
    logic wrOk;      // written code inside the channel window
  } dpStat_t;

endpackage

// File: rtl/dvs_ramp_dp.sv
module dvs_ramp_dp
  import dvs_pkg::*;
#(
  parameter int CW   = 5,
  parameter int LO   = 4,
  parameter int HI   = 24,
  parameter int INIT = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] wrCode,
  input  dpStrb_t       strb,
  output logic [CW-1:0] cur,
  output dpStat_t       stat
);

  localparam logic [CW-1:0] LO_C   = CW'(LO);
  localparam logic [CW-1:0] HI_C   = CW'(HI);
  localparam logic [CW-1:0] INIT_C = CW'(INIT);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [CW-1:0] tgt;

  always_comb begin
    stat.wrOk     = (wrCode >= LO_C) && (wrCode <= HI_C);
    stat.eq       = (cur == tgt);
    stat.tgtAbove = (tgt > cur);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgt <= INIT_C;
      cur <= INIT_C;
    end else begin
      if (strb.load) tgt <= wrCode;
      if (strb.snap)        cur <= strb.load ? wrCode : tgt;
      else if (strb.stepUp) cur <= cur + ONE;
      else if (strb.stepDn) cur <= cur - ONE;
    end
  end

  // R2: applied code never leaves the window
  a_r2_in_window: assert property (@(posedge clk) disable iff (!rstN)
    (cur >= LO_C) && (cur <= HI_C));

  // R5: without a jump, the code moves by at most one per cycle
  a_r5_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.snap && !strb.load) |=>
      (cur == $past(cur) || cur == $past(cur) + ONE || cur == $past(cur) - ONE));

  // R3: target held unless a write is accepted
  a_r3_tgt_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(tgt));

endmodule

// File: rtl/dvs_ramp_ctrl.sv
module dvs_ramp_ctrl
  import dvs_pkg::*;
#(
  parameter int DWELL = 6400
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    microStepEn,
  input  logic    wrStb,
  input  dpStat_t stat,
  output dpStrb_t strb,
  output logic    busy,
  output logic    done
);

  localparam int CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL - 1);

  logic [CNT_W-1:0] dwellCnt;
  logic pendQ;
  logic wrAcc;
  logic tick;
  logic walk;

  always_comb begin
    wrAcc       = wrStb && stat.wrOk;
    tick        = (dwellCnt == LAST);
    walk        = microStepEn && !wrAcc && !stat.eq && tick;
    strb.load   = wrAcc;
    strb.snap   = !microStepEn && (wrAcc || !stat.eq);
    strb.stepUp = walk && stat.tgtAbove;
    strb.stepDn = walk && !stat.tgtAbove;
    busy        = !stat.eq;
    done        = pendQ && stat.eq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dwellCnt <= '0;
      pendQ    <= 1'b0;
    end else begin
      if (wrAcc || stat.eq || !microStepEn || tick) dwellCnt <= '0;
      else                                          dwellCnt <= dwellCnt + CNT_W'(1);
      if (wrAcc)     pendQ <= 1'b1;
      else if (done) pendQ <= 1'b0;
    end
  end

  // R9: done lasts exactly one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: done and busy never overlap
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R5: two steps are never taken in adjacent cycles
  a_r5_no_adjacent_steps: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepUp || strb.stepDn) |=> !(strb.stepUp || strb.stepDn));

  // R10: with stepping disabled the channel is settled one edge later
  a_r10_snap: assert property (@(posedge clk) disable iff (!rstN)
    !microStepEn |=> !busy);

endmodule

// File: rtl/dvs_ramp_seq.sv
module dvs_ramp_seq
  import dvs_pkg::*;
#(
  parameter int CLK_HZ   = 200_000_000,
  parameter int DWELL_US = 32,
  parameter int CW       = 5,
  parameter int CH0_LO   = 4,
  parameter int CH0_HI   = 24,
  parameter int CH0_INIT = 8,
  parameter int CH1_LO   = 10,
  parameter int CH1_HI   = 25,
  parameter int CH1_INIT = 25
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          microStepEn,
  input  logic          wrStb0,
  input  logic [CW-1:0] wrCode0,
  input  logic          wrStb1,
  input  logic [CW-1:0] wrCode1,
  output logic [CW-1:0] code0,
  output logic          busy0,
  output logic          done0,
  output logic [CW-1:0] code1,
  output logic          busy1,
  output logic          done1
);

  // R11: dwell length in clock cycles
  localparam longint DWELL_L = (longint'(CLK_HZ) * longint'(DWELL_US)) / 64'd1_000_000;
  localparam int     DWELL   = (DWELL_L < 2) ? 2 : int'(DWELL_L);
  localparam int     NCH     = 2;
  localparam int     LO_A   [NCH] = '{CH0_LO, CH1_LO};
  localparam int     HI_A   [NCH] = '{CH0_HI, CH1_HI};
  localparam int     INIT_A [NCH] = '{CH0_INIT, CH1_INIT};

  logic          wrStbA  [NCH];
  logic [CW-1:0] wrCodeA [NCH];
  logic [CW-1:0] codeA   [NCH];
  logic          busyA   [NCH];
  logic          doneA   [NCH];

  assign wrStbA[0]  = wrStb0;
  assign wrStbA[1]  = wrStb1;
  assign wrCodeA[0] = wrCode0;
  assign wrCodeA[1] = wrCode1;
  assign code0 = codeA[0];
  assign busy0 = busyA[0];
  assign done0 = doneA[0];
  assign code1 = codeA[1];
  assign busy1 = busyA[1];
  assign done1 = doneA[1];

  // R12: one independent controller/datapath pair per channel
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dpStrb_t strb;
    dpStat_t stat;

    dvs_ramp_ctrl #(.DWELL(DWELL)) u_ctrl (
      .clk(clk), .rstN(rstN), .microStepEn(microStepEn),
      .wrStb(wrStbA[g]), .stat(stat), .strb(strb),
      .busy(busyA[g]), .done(doneA[g])
    );

    dvs_ramp_dp #(.CW(CW), .LO(LO_A[g]), .HI(HI_A[g]), .INIT(INIT_A[g])) u_dp (
      .clk(clk), .rstN(rstN), .wrCode(wrCodeA[g]), .strb(strb),
      .cur(codeA[g]), .stat(stat)
    );
  end

endmodule

// File: tb/sim_dvs_ramp_seq.sv
module sim_dvs_ramp_seq;

  localparam int DW = 32;  // CLK_HZ 1 MHz x 32 us

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic microStepEn = 1'b0;
  logic wrStb0 = 1'b0, wrStb1 = 1'b0;
  logic [4:0] wrCode0 = '0, wrCode1 = '0;
  logic [4:0] code0, code1;
  logic busy0, busy1, done0, done1;

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;
  int model [2];

  always #2.5 clk = ~clk;

  dvs_ramp_seq #(.CLK_HZ(1_000_000), .DWELL_US(32)) u0 (
    .clk(clk), .rstN(rstN), .microStepEn(microStepEn),
    .wrStb0(wrStb0), .wrCode0(wrCode0), .wrStb1(wrStb1), .wrCode1(wrCode1),
    .code0(code0), .busy0(busy0), .done0(done0),
    .code1(code1), .busy1(busy1), .done1(done1)
  );

  // vector: {channel, microStepEn, code}
  localparam logic [6:0] VEC [12] = '{
    {1'b0, 1'b0, 5'd12},  // R4 immediate
    {1'b0, 1'b0, 5'd3},   // R3 below window
    {1'b0, 1'b1, 5'd16},  // R5 up 4
    {1'b0, 1'b1, 5'd4},   // R6 down 12 to low edge
    {1'b0, 1'b1, 5'd25},  // R3 above window
    {1'b0, 1'b1, 5'd24},  // R6 full span, 20 steps
    {1'b1, 1'b1, 5'd9},   // R3 below window
    {1'b1, 1'b1, 5'd18},  // R5 down 7
    {1'b1, 1'b0, 5'd10},  // R4 immediate to low edge
    {1'b1, 1'b1, 5'd26},  // R3 above window
    {1'b1, 1'b1, 5'd10},  // R9 same code
    {1'b0, 1'b1, 5'd20}   // R5 down 4
  };

  function automatic int codeOf(int ch);
    return (ch == 0) ? int'(code0) : int'(code1);
  endfunction
  function automatic bit busyOf(int ch);
    return (ch == 0) ? busy0 : busy1;
  endfunction
  function automatic bit doneOf(int ch);
    return (ch == 0) ? done0 : done1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, return at the negedge after the sampling edge (m=0)
  task automatic wr(int ch, int code, bit ms);
    @(negedge clk);
    microStepEn = ms;
    if (ch == 0) begin wrStb0 = 1'b1; wrCode0 = 5'(code); end
    else         begin wrStb1 = 1'b1; wrCode1 = 5'(code); end
    @(negedge clk);
    wrStb0 = 1'b0;
    wrStb1 = 1'b0;
  endtask

  task automatic adv(int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic bit inWin(int ch, int c);
    return (ch == 0) ? (c >= 4 && c <= 24) : (c >= 10 && c <= 25);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    model[0] = 8;
    model[1] = 25;
    adv(3);
    // R1 reset state
    chk(code0 == 5'd8,  "R1 code0", int'(code0), 8);
    chk(code1 == 5'd25, "R1 code1", int'(code1), 25);
    chk({busy0, busy1, done0, done1} == 4'b0, "R1 flags", int'({busy0, busy1, done0, done1}), 0);
    rstN = 1'b1;
    adv(2);

    for (int i = 0; i < 12; i++) begin
      int ch, code, prev, n, dir, fin, oth;
      bit ms;
      ch = int'(VEC[i][6]);
      ms = VEC[i][5];
      code = int'(VEC[i][4:0]);
      prev = model[ch];
      oth = 1 - ch;
      fin = inWin(ch, code) ? code : prev;
      n = (fin > prev) ? fin - prev : prev - fin;
      dir = (fin > prev) ? 1 : -1;
      wr(ch, code, ms);
      if (!inWin(ch, code)) begin
        chk(codeOf(ch) == prev && !busyOf(ch), "R3 ignored at m0", codeOf(ch), prev);
        adv(DW + 1);
        chk(codeOf(ch) == prev && !doneOf(ch) && !busyOf(ch), "R3 ignored later", codeOf(ch), prev);
      end else if (!ms || n == 0) begin
        chk(codeOf(ch) == fin, "R4 applied next edge", codeOf(ch), fin);
        chk(doneOf(ch), "R9 done pulse", int'(doneOf(ch)), 1);
        adv(1);
        chk(!doneOf(ch), "R9 done width", int'(doneOf(ch)), 0);
      end else begin
        chk(busyOf(ch), "R8 busy during ramp", int'(busyOf(ch)), 1);
        adv(DW - 1);
        chk(codeOf(ch) == prev, "R5 held before first step", codeOf(ch), prev);
        adv(1);
        chk(codeOf(ch) == prev + dir, "R5 first step", codeOf(ch), prev + dir);
        adv((n - 1) * DW - 1);
        chk(codeOf(ch) == fin - dir && busyOf(ch), "R6 one short", codeOf(ch), fin - dir);
        adv(1);
        chk(codeOf(ch) == fin && !busyOf(ch), "R6 reached at n*DWELL", codeOf(ch), fin);
        chk(doneOf(ch), "R9 done pulse", int'(doneOf(ch)), 1);
        adv(1);
        chk(!doneOf(ch), "R9 done width", int'(doneOf(ch)), 0);
      end
      model[ch] = fin;
      chk(codeOf(oth) == model[oth], "R12 other channel untouched", codeOf(oth), model[oth]);
    end

    // R7 mid-ramp retarget (channel 0 at 20)
    wr(0, 24, 1'b1);
    adv(2 * DW + 4);
    chk(code0 == 5'd22, "R7 progress before retarget", int'(code0), 22);
    wr(0, 20, 1'b1);
    adv(DW - 1);
    chk(code0 == 5'd22, "R7 dwell restarted", int'(code0), 22);
    adv(1);
    chk(code0 == 5'd21, "R7 reversed step", int'(code0), 21);
    adv(DW);
    chk(code0 == 5'd20 && done0, "R7 reached new target", int'(code0), 20);
    adv(2);

    // R10 disable stepping mid-ramp (channel 1 at 10)
    wr(1, 20, 1'b1);
    adv(DW + 2);
    chk(code1 == 5'd11, "R10 one step taken", int'(code1), 11);
    @(negedge clk);
    microStepEn = 1'b0;
    @(negedge clk);
    chk(code1 == 5'd20 && !busy1, "R10 snapped to target", int'(code1), 20);
    chk(done1, "R10 done on snap", int'(done1), 1);
    adv(2);

    // R12 both channels together: ch0 20->21, ch1 20->18
    @(negedge clk);
    microStepEn = 1'b1;
    wrStb0 = 1'b1; wrCode0 = 5'd21;
    wrStb1 = 1'b1; wrCode1 = 5'd18;
    @(negedge clk);
    wrStb0 = 1'b0; wrStb1 = 1'b0;
    adv(DW);
    chk(code0 == 5'd21 && done0, "R12 ch0 finished", int'(code0), 21);
    chk(code1 == 5'd19 && busy1, "R12 ch1 midway", int'(code1), 19);
    adv(DW);
    chk(code1 == 5'd18 && done1, "R12 ch1 finished", int'(code1), 18);
    chk(code0 == 5'd21 && !done0, "R12 ch0 still", int'(code0), 21);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule